// File: doc/BRIEF.md
# Sign-Steered Bit/Sample Correlation Accumulator

This block holds a matrix of running correlations between a vector of antipodal bits and a vector of signed received samples, kept over a sliding window. There are `2*NUM_USERS` rows, one per bit lane, and `NUM_TAPS` columns, one per sample lane. Each entry is an `ACC_W`-bit two's-complement accumulator.

On every update strobe the caller presents two pairs of vectors. The first pair is the bit vector and sample vector that just entered the window. The second pair is the bit vector and sample vector that just left it. Each entry adds the product of its entering bit and entering sample, and takes away the product of its departing bit and departing sample. Because a bit stands for +1 or -1, each product is the sample or its negation. Every entry therefore needs only a sign-steered adder and no multiplier.

A synchronous clear empties the matrix, for example at the start of a new window. Any one entry can be read at any time by giving a row and column index. The read data is combinational from the stored state.

Top module: `xcorr_updater`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every entry reads 0.
- R2: Row r takes bit r of `new_bits_i` and `old_bits_i`. Column c takes bits [c*SAMPLE_W+SAMPLE_W-1 : c*SAMPLE_W] of `new_samp_i` and `old_samp_i`. `rd_data_o` shows the entry at (`rd_row_i`, `rd_col_i`).
- R3: Entering term: a new bit of 1 adds the sample to the entry, and a new bit of 0 subtracts it.
- R4: Departing term: an old bit of 1 subtracts the old sample from the entry, and an old bit of 0 adds it.
- R5: When `upd_i` is high at a clock edge, every entry takes both terms at that edge. The result is readable from the next cycle.
- R6: With `upd_i` and `clr_i` low, no entry changes, whatever the data inputs do.
- R7: `clr_i` high at a clock edge zeroes every entry. It takes priority over a simultaneous `upd_i`.
- R8: Samples are two's complement, and the extreme values -128 and +127 are handled exactly, including the negation of -128.
- R9: Entries wrap modulo 2^ACC_W on overflow. This is the intended behaviour.
- R10: A row index of 2*NUM_USERS or more, or a column index of NUM_TAPS or more, reads 0.
- R11: An update whose entering and departing bits and samples are identical leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of all entries |
| upd_i | input | 1 | Update strobe |
| new_bits_i | input | 2*NUM_USERS | Entering bit vector, 1 = +1, 0 = -1 |
| new_samp_i | input | NUM_TAPS*SAMPLE_W | Entering samples, packed by column |
| old_bits_i | input | 2*NUM_USERS | Departing bit vector |
| old_samp_i | input | NUM_TAPS*SAMPLE_W | Departing samples, packed by column |
| rd_row_i | input | $clog2(2*NUM_USERS+1) | Read row index |
| rd_col_i | input | $clog2(NUM_TAPS+1) | Read column index |
| rd_data_o | output | ACC_W | Selected entry |

## Verification
The bench builds the block with NUM_USERS=3 and NUM_TAPS=5, giving a 6-by-5 matrix. Neither dimension is a power of two, so index values just past the edge (rows 6 and 7, columns 5 to 7) fit in the index ports. This brings the out-of-range read path within reach. Keeping SAMPLE_W=8 and ACC_W=16 lets a run of about 130 full-scale updates drive an entry past +32767, which exercises the wrap.

// File: rtl/xcu_pkg.sv
package xcu_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_CLEAR = 2'd2
    } cell_op_e;

    typedef struct packed {
        logic add_bit;
        logic rm_bit;
    } bit_pair_t;

    // clear outranks the update strobe
    function automatic cell_op_e decode_op(input logic clr, input logic upd);
        if (clr)      return OP_CLEAR;
        else if (upd) return OP_STEP;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/xcu_ctrl.sv
module xcu_ctrl
    import xcu_pkg::*;
(
    input  logic     clr_i,
    input  logic     upd_i,
    output cell_op_e op_o
);
    always_comb op_o = decode_op(clr_i, upd_i);
endmodule

// File: rtl/xcu_term.sv
module xcu_term
    import xcu_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 16
) (
    input  bit_pair_t            bits_i,
    input  logic [SAMPLE_W-1:0]  add_samp_i,
    input  logic [SAMPLE_W-1:0]  rm_samp_i,
    output logic [ACC_W-1:0]     delta_o
);
    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic [ACC_W-1:0] add_ext, rm_ext, add_term, rm_term;

    always_comb begin
        add_ext  = {{EXT_W{add_samp_i[SAMPLE_W-1]}}, add_samp_i};
        rm_ext   = {{EXT_W{rm_samp_i[SAMPLE_W-1]}}, rm_samp_i};
        // bit 1 -> +sample, bit 0 -> -sample
        add_term = bits_i.add_bit ? add_ext : (~add_ext + 1'b1);
        rm_term  = bits_i.rm_bit  ? rm_ext  : (~rm_ext + 1'b1);
        delta_o  = add_term - rm_term;
    end
endmodule

// File: rtl/xcu_cell.sv
module xcu_cell
    import xcu_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_op_e         op_i,
    input  logic [ACC_W-1:0] delta_i,
    output logic [ACC_W-1:0] acc_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else begin
            unique case (op_i)
                OP_CLEAR: acc_o <= '0;
                OP_STEP:  acc_o <= acc_o + delta_i;
                default:  acc_o <= acc_o;
            endcase
        end
    end
endmodule

// File: rtl/xcu_rdmux.sv
module xcu_rdmux #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int ACC_W  = 16,
    parameter int ROW_IW = 3,
    parameter int COL_IW = 3
) (
    input  logic [ROWS*COLS*ACC_W-1:0] acc_flat_i,
    input  logic [ROW_IW-1:0]          row_i,
    input  logic [COL_IW-1:0]          col_i,
    output logic [ACC_W-1:0]           data_o
);
    int unsigned r_idx, c_idx;

    always_comb begin
        r_idx  = 32'(row_i);
        c_idx  = 32'(col_i);
        data_o = '0;
        if (r_idx < ROWS && c_idx < COLS)
            data_o = acc_flat_i[(r_idx*COLS + c_idx)*ACC_W +: ACC_W];
    end
endmodule

// File: rtl/xcorr_updater.sv
module xcorr_updater
    import xcu_pkg::*;
#(
    parameter int NUM_USERS = 2,
    parameter int NUM_TAPS  = 4,
    parameter int SAMPLE_W  = 8,
    parameter int ACC_W     = 16,
    localparam int ROWS     = 2 * NUM_USERS,
    localparam int ROW_IW   = $clog2(ROWS + 1),
    localparam int COL_IW   = $clog2(NUM_TAPS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_i,
    input  logic                         upd_i,
    input  logic [ROWS-1:0]              new_bits_i,
    input  logic [NUM_TAPS*SAMPLE_W-1:0] new_samp_i,
    input  logic [ROWS-1:0]              old_bits_i,
    input  logic [NUM_TAPS*SAMPLE_W-1:0] old_samp_i,
    input  logic [ROW_IW-1:0]            rd_row_i,
    input  logic [COL_IW-1:0]            rd_col_i,
    output logic [ACC_W-1:0]             rd_data_o
);
    localparam int CELLS = ROWS * NUM_TAPS;

    cell_op_e                 op;
    logic [CELLS*ACC_W-1:0]   acc_flat;

    xcu_ctrl u_ctrl (
        .clr_i (clr_i),
        .upd_i (upd_i),
        .op_o  (op)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        bit_pair_t row_bits;
        assign row_bits = '{add_bit: new_bits_i[r], rm_bit: old_bits_i[r]};

        for (genvar c = 0; c < NUM_TAPS; c++) begin : g_col
            logic [ACC_W-1:0] delta;

            xcu_term #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_term (
                .bits_i     (row_bits),
                .add_samp_i (new_samp_i[c*SAMPLE_W +: SAMPLE_W]),
                .rm_samp_i  (old_samp_i[c*SAMPLE_W +: SAMPLE_W]),
                .delta_o    (delta)
            );

            xcu_cell #(.ACC_W(ACC_W)) u_cell (
                .clk     (clk),
                .rst     (rst),
                .op_i    (op),
                .delta_i (delta),
                .acc_o   (acc_flat[(r*NUM_TAPS + c)*ACC_W +: ACC_W])
            );
        end
    end

    xcu_rdmux #(
        .ROWS(ROWS), .COLS(NUM_TAPS), .ACC_W(ACC_W),
        .ROW_IW(ROW_IW), .COL_IW(COL_IW)
    ) u_rdmux (
        .acc_flat_i (acc_flat),
        .row_i      (rd_row_i),
        .col_i      (rd_col_i),
        .data_o     (rd_data_o)
    );
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
    parameter int NUM_USERS = 2,
    parameter int NUM_TAPS  = 4,
    parameter int SAMPLE_W  = 8,
    parameter int ACC_W     = 16,
    localparam int ROWS     = 2 * NUM_USERS,
    localparam int ROW_IW   = $clog2(ROWS + 1),
    localparam int COL_IW   = $clog2(NUM_TAPS + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         clr_i,
    input logic                         upd_i,
    input logic [ROWS-1:0]              new_bits_i,
    input logic [NUM_TAPS*SAMPLE_W-1:0] new_samp_i,
    input logic [ROWS-1:0]              old_bits_i,
    input logic [NUM_TAPS*SAMPLE_W-1:0] old_samp_i,
    input logic [ROW_IW-1:0]            rd_row_i,
    input logic [COL_IW-1:0]            rd_col_i,
    input logic [ACC_W-1:0]             rd_data_o
);
    logic             in_range;
    int               sel_r, sel_c, s_new, s_old, exp_d;
    logic             same_io;

    always_comb begin
        in_range = (int'(rd_row_i) < ROWS) && (int'(rd_col_i) < NUM_TAPS);
        sel_r    = in_range ? int'(rd_row_i) : 0;
        sel_c    = in_range ? int'(rd_col_i) : 0;
        s_new    = int'($signed(new_samp_i[sel_c*SAMPLE_W +: SAMPLE_W]));
        s_old    = int'($signed(old_samp_i[sel_c*SAMPLE_W +: SAMPLE_W]));
        exp_d    = (new_bits_i[sel_r] ? s_new : -s_new)
                 - (old_bits_i[sel_r] ? s_old : -s_old);
        same_io  = (new_bits_i == old_bits_i) && (new_samp_i == old_samp_i);
    end

    logic              rst_q, clr_q, step_q, hold_q, cancel_q;
    logic [ROW_IW-1:0] row_q;
    logic [COL_IW-1:0] col_q;
    logic [ACC_W-1:0]  data_q, exp_q;

    always_ff @(posedge clk) begin
        rst_q    <= rst;
        clr_q    <= clr_i & ~rst;
        step_q   <= ~rst & ~clr_i & upd_i & in_range;
        cancel_q <= ~rst & ~clr_i & upd_i & in_range & same_io;
        hold_q   <= ~rst & ~clr_i & ~upd_i & in_range;
        row_q    <= rd_row_i;
        col_q    <= rd_col_i;
        data_q   <= rd_data_o;
        exp_q    <= ACC_W'(int'(rd_data_o) + exp_d);
    end

    logic same_idx;
    assign same_idx = (rd_row_i == row_q) && (rd_col_i == col_q);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst_q |-> rd_data_o == '0);

    assert_step_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (step_q && same_idx) |-> rd_data_o == exp_q);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (hold_q && same_idx) |-> rd_data_o == data_q);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr_q |-> rd_data_o == '0);

    assert_oob_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> rd_data_o == '0);

    assert_cancel_R11: assert property (@(posedge clk) disable iff (rst)
        (cancel_q && same_idx) |-> rd_data_o == data_q);
endmodule

bind xcorr_updater xcu_checker #(
    .NUM_USERS(NUM_USERS), .NUM_TAPS(NUM_TAPS),
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)
) u_xcu_checker (
    .clk(clk), .rst(rst), .clr_i(clr_i), .upd_i(upd_i),
    .new_bits_i(new_bits_i), .new_samp_i(new_samp_i),
    .old_bits_i(old_bits_i), .old_samp_i(old_samp_i),
    .rd_row_i(rd_row_i), .rd_col_i(rd_col_i), .rd_data_o(rd_data_o)
);

// File: tb/xcorr_updater_bench.sv
`timescale 1ns/1ps
module xcorr_updater_bench;
    localparam int K    = 3;
    localparam int N    = 5;
    localparam int SW   = 8;
    localparam int AW   = 16;
    localparam int ROWS = 2 * K;
    localparam int RIW  = $clog2(ROWS + 1);
    localparam int CIW  = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              upd = 1'b0;
    logic [ROWS-1:0]   nb = '0, ob = '0;
    logic [N*SW-1:0]   ns = '0, os = '0;
    logic [RIW-1:0]    rrow = '0;
    logic [CIW-1:0]    rcol = '0;
    logic [AW-1:0]     rdat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [AW-1:0] mdl [ROWS][N];

    always #4 clk = ~clk;

    xcorr_updater #(.NUM_USERS(K), .NUM_TAPS(N), .SAMPLE_W(SW), .ACC_W(AW))
    u_xcorr_updater (
        .clk(clk), .rst(rst), .clr_i(clr), .upd_i(upd),
        .new_bits_i(nb), .new_samp_i(ns), .old_bits_i(ob), .old_samp_i(os),
        .rd_row_i(rrow), .rd_col_i(rcol), .rd_data_o(rdat)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s row=%0d col=%0d actual=%h expected=%h", tag, rrow, rcol, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < N; c++) mdl[r][c] = '0;
    endtask

    task automatic model_step(input logic [ROWS-1:0] b1, input logic [N*SW-1:0] s1,
                              input logic [ROWS-1:0] b0, input logic [N*SW-1:0] s0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < N; c++) begin
                int a, d;
                a = int'($signed(s1[c*SW +: SW]));
                d = int'($signed(s0[c*SW +: SW]));
                mdl[r][c] = AW'(int'(mdl[r][c]) + (b1[r] ? a : -a) - (b0[r] ? d : -d));
            end
    endtask

    task automatic step(input logic [ROWS-1:0] b1, input logic [N*SW-1:0] s1,
                        input logic [ROWS-1:0] b0, input logic [N*SW-1:0] s0);
        @(negedge clk);
        nb = b1; ns = s1; ob = b0; os = s0; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        model_step(b1, s1, b0, s0);
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                rrow = RIW'(r); rcol = CIW'(c);
                #1 check(tag, rdat, mdl[r][c]);
            end
    endtask

    task automatic t_reset();
        model_zero();
        check_all("R1");
    endtask

    task automatic t_add();      // R3: departing samples zero
        step(6'b101101, {8'sd7, -8'sd3, 8'sd20, 8'sd1, -8'sd50}, 6'b010011, '0);
        check_all("R3");
    endtask

    task automatic t_remove();   // R4: entering samples zero
        step(6'b111000, '0, 6'b100110, {8'sd9, 8'sd4, -8'sd11, 8'sd33, -8'sd2});
        check_all("R4");
    endtask

    task automatic t_both();     // R5, R2: distinct per-lane values
        step(6'b011010, {8'sd10, 8'sd20, 8'sd30, 8'sd40, 8'sd50},
             6'b110001, {-8'sd5, 8'sd15, -8'sd25, 8'sd35, -8'sd45});
        check_all("R5");
        step(6'b000001, {8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd1},
             6'b000001, {8'sd0, 8'sd0, 8'sd0, 8'sd2, 8'sd0});
        check_all("R2");
    endtask

    task automatic t_hold();     // R6: inputs wiggle, strobe low
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nb = ROWS'(i * 13); ob = ~nb;
            ns = {N{8'(i * 37 + 5)}}; os = ~ns;
        end
        check_all("R6");
    endtask

    task automatic t_cancel();   // R11
        step(6'b100101, {8'sd90, -8'sd90, 8'sd1, -8'sd128, 8'sd127},
             6'b100101, {8'sd90, -8'sd90, 8'sd1, -8'sd128, 8'sd127});
        check_all("R11");
    endtask

    task automatic t_extreme();  // R8: -128 negated and +127
        step(6'b010101, {-8'sd128, 8'sd127, -8'sd128, 8'sd127, -8'sd1},
             6'b011001, {8'sd127, -8'sd128, -8'sd128, 8'sd127, -8'sd128});
        check_all("R8");
    endtask

    task automatic t_clear();    // R7: plain clear, then clear with strobe
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_zero();
        check_all("R7");
        step(6'b111111, {N{8'sd3}}, '0, {N{8'sd3}});
        @(negedge clk);
        clr = 1'b1; upd = 1'b1; nb = '1; ns = {N{8'sd100}};
        @(negedge clk);
        clr = 1'b0; upd = 1'b0;
        model_zero();
        check_all("R7");
    endtask

    task automatic t_wrap();     // R9: 130 x 254 = 33020 -> 16'h80FC
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_zero();
        for (int i = 0; i < 130; i++)
            step('1, {N{8'sd127}}, '0, {N{8'sd127}});
        check_all("R9");
        @(negedge clk); rrow = 3'd2; rcol = 3'd4;
        #1 check("R9", rdat, 16'h80FC);
    endtask

    task automatic t_oob();      // R10
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (r >= ROWS || c >= N) begin
                    @(negedge clk);
                    rrow = RIW'(r); rcol = CIW'(c);
                    #1 check("R10", rdat, '0);
                end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_remove();
        t_both();
        t_hold();
        t_cancel();
        t_extreme();
        t_clear();
        t_wrap();
        t_oob();
        finish_run();
    end
endmodule